// File: doc/BRIEF.md
# LCD Panel Timing Generator

This block produces the raster timing for a parallel RGB panel: horizontal sync, vertical sync, a data-enable strobe and the column and row of the pixel being shown. It steps once per pixel-clock enable and reads its line and frame geometry from a small bank of configuration registers. All of these registers are copied into a shadow set at each frame boundary, so a frame never runs with mixed timing. Each sync output has its own polarity control. A 2-bit bus-format code is forwarded to the pixel datapath.

Each frame boundary raises a start-of-frame event. The event sets a sticky status bit. A mask bit gates that status onto the interrupt line. Software sets the mask through an enable register and clears it through a disable register. Reading the status register clears the status bit.

One generic phase machine is used twice, once per axis. Its states are SYNC, BACK, ACTIVE and FRONT. On a step whose counter has reached the limit of the current state, the machine moves SYNC→BACK, BACK→ACTIVE, ACTIVE→FRONT and FRONT→SYNC, and the counter restarts at zero. In the vertical machine, SYNC→ACTIVE replaces SYNC→BACK when the back porch is zero. The horizontal machine steps on the pixel enable. The vertical machine steps on the horizontal FRONT→SYNC wrap, and its own wrap marks the frame boundary.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset both machines sit in SYNC with a zero count. hsync and vsync are at 1, de, pix_x, pix_y, out_mode and irq are 0, and the status register reads 0. The reset configuration is all zero, which gives a 4-pixel line and a 3-line frame with no vertical back porch.
- R2: A line runs sync, back porch, active, front porch. The horizontal lengths are field+1 each. Register 0 bits 15:0 hold the sync width. Register 2 bits 15:0 hold the front porch and bits 31:16 hold the back porch. Register 3 bits 15:0 hold the active width.
- R3: A frame runs the same four phases, counted in lines. Register 0 bits 31:16 hold the vertical sync width minus one. Register 1 bits 15:0 hold the front porch minus one. Register 1 bits 31:16 hold the back porch as its true line count, and zero means no back-porch lines. Register 3 bits 31:16 hold the active height minus one.
- R4: de is 1 only when both axes are in the active phase. pix_x is the column within the active width and is 0 outside it. pix_y is the row within the active height and is 0 outside it.
- R5: In register 4, bit 0 inverts hsync and bit 1 inverts vsync. With a bit clear, the sync output is 1 during its sync phase.
- R6: Register 4 bits 9:8 drive out_mode. The codes are 0 RGB444, 1 RGB565, 2 RGB666 and 3 RGB888.
- R7: Writes to registers 0 to 4 take effect only from the first pixel of the next frame.
- R8: The machines advance only in cycles with pix_ce high. With pix_ce low, every timing output holds.
- R9: The start-of-frame event sets the status bit (register 7, bit 0). The bit stays set until register 7 is read. A read clears it, except that a same-cycle event wins over the clear.
- R10: irq is the status bit gated by the mask (register 7, bit 1). Writing 1 to bit 0 of register 5 sets the mask. Writing 1 to bit 0 of register 6 clears it, and irq falls in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_ce | input | 1 | Pixel-clock enable, one pixel per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe (clears status on register 7) |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data, valid in the strobe cycle |
| hsync | output | 1 | Horizontal sync, polarity per register 4 bit 0 |
| vsync | output | 1 | Vertical sync, polarity per register 4 bit 1 |
| de | output | 1 | Data enable |
| pix_x | output | 16 | Active column |
| pix_y | output | 16 | Active row |
| out_mode | output | 2 | Bus-format code |
| irq | output | 1 | Masked start-of-frame interrupt |

## Verification
The bench builds the expected pixel stream frame by frame from the true geometry and compares every enabled pixel against it. Any off-by-one in a minus-one field, or treating the vertical back porch as minus-one, therefore shifts the whole stream and is reported. The new geometry is written in the middle of a running frame, so a design that applied it at once would produce a frame with mixed timing. The enable is held low on every third cycle, which catches a design that counts raw clocks. A zero back porch exercises the SYNC→ACTIVE skip, and a design that still inserts a line would misalign every later row. The interrupt tests read status twice, toggle the mask with status held, and stall the pixel clock while irq is high. These catch a status that is not sticky, a read that does not clear, and a disable that does not gate irq.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    localparam int FLD_W  = 16;
    localparam int REG_W  = 2 * FLD_W;
    localparam int ADDR_W = 3;
    localparam int FMT_W  = 2;
    localparam int FMT_LSB = 8;

    localparam logic [ADDR_W-1:0] A_SYNC = 3'd0;
    localparam logic [ADDR_W-1:0] A_VPOR = 3'd1;
    localparam logic [ADDR_W-1:0] A_HPOR = 3'd2;
    localparam logic [ADDR_W-1:0] A_AREA = 3'd3;
    localparam logic [ADDR_W-1:0] A_MODE = 3'd4;
    localparam logic [ADDR_W-1:0] A_IEN  = 3'd5;
    localparam logic [ADDR_W-1:0] A_IDIS = 3'd6;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd7;

    typedef enum logic [1:0] {
        PH_SYNC   = 2'd0,
        PH_BACK   = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_FRONT  = 2'd3
    } phase_e;

    typedef struct packed {
        logic [FLD_W-1:0] hsw_m1;
        logic [FLD_W-1:0] hbp_m1;
        logic [FLD_W-1:0] wid_m1;
        logic [FLD_W-1:0] hfp_m1;
        logic [FLD_W-1:0] vsw_m1;
        logic [FLD_W-1:0] vbp;
        logic [FLD_W-1:0] hgt_m1;
        logic [FLD_W-1:0] vfp_m1;
        logic             hs_inv;
        logic             vs_inv;
        logic [FMT_W-1:0] fmt;
    } timing_t;

endpackage

// File: rtl/lcdt_phase_fsm.sv
module lcdt_phase_fsm
    import lcdt_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [CW-1:0] lim_sync,
    input  logic [CW-1:0] lim_back,
    input  logic [CW-1:0] lim_act,
    input  logic [CW-1:0] lim_front,
    input  logic          skip_back,
    output phase_e        phase,
    output logic [CW-1:0] cnt,
    output logic          wrap
);

    phase_e        nxt_phase;
    logic [CW-1:0] cur_lim;
    logic          at_lim;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_SYNC;
            cnt   <= '0;
        end else if (step) begin
            if (at_lim) begin
                phase <= nxt_phase;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // next state and outputs
    always_comb begin
        cur_lim   = lim_sync;
        nxt_phase = PH_SYNC;
        unique case (phase)
            PH_SYNC: begin
                cur_lim   = lim_sync;
                nxt_phase = skip_back ? PH_ACTIVE : PH_BACK;
            end
            PH_BACK: begin
                cur_lim   = lim_back;
                nxt_phase = PH_ACTIVE;
            end
            PH_ACTIVE: begin
                cur_lim   = lim_act;
                nxt_phase = PH_FRONT;
            end
            PH_FRONT: begin
                cur_lim   = lim_front;
                nxt_phase = PH_SYNC;
            end
        endcase
        at_lim = (cnt == cur_lim);
        wrap   = step && at_lim && (phase == PH_FRONT);
    end

endmodule

// File: rtl/lcdt_regs.sv
module lcdt_regs
    import lcdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              frame_end,
    input  logic              stat_q,
    input  logic              mask_q,
    output timing_t           sh_cfg,
    output logic [REG_W-1:0]  rd_data
);

    timing_t live;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_SYNC: begin
                    live.hsw_m1 <= wr_data[FLD_W-1:0];
                    live.vsw_m1 <= wr_data[REG_W-1:FLD_W];
                end
                A_VPOR: begin
                    live.vfp_m1 <= wr_data[FLD_W-1:0];
                    live.vbp    <= wr_data[REG_W-1:FLD_W];
                end
                A_HPOR: begin
                    live.hfp_m1 <= wr_data[FLD_W-1:0];
                    live.hbp_m1 <= wr_data[REG_W-1:FLD_W];
                end
                A_AREA: begin
                    live.wid_m1 <= wr_data[FLD_W-1:0];
                    live.hgt_m1 <= wr_data[REG_W-1:FLD_W];
                end
                A_MODE: begin
                    live.hs_inv <= wr_data[0];
                    live.vs_inv <= wr_data[1];
                    live.fmt    <= wr_data[FMT_LSB+FMT_W-1:FMT_LSB];
                end
                default: ;
            endcase
        end
    end

    // shadow copy taken only at the frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_cfg <= '0;
        end else if (frame_end) begin
            sh_cfg <= live;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_SYNC: rd_data = {live.vsw_m1, live.hsw_m1};
            A_VPOR: rd_data = {live.vbp, live.vfp_m1};
            A_HPOR: rd_data = {live.hbp_m1, live.hfp_m1};
            A_AREA: rd_data = {live.hgt_m1, live.wid_m1};
            A_MODE: begin
                rd_data[0] = live.hs_inv;
                rd_data[1] = live.vs_inv;
                rd_data[FMT_LSB+FMT_W-1:FMT_LSB] = live.fmt;
            end
            A_STAT: begin
                rd_data[0] = stat_q;
                rd_data[1] = mask_q;
            end
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/lcdt_irq.sv
module lcdt_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic sof,
    input  logic stat_clr,
    input  logic mask_set,
    input  logic mask_clr,
    output logic stat_q,
    output logic mask_q,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= 1'b0;
            mask_q <= 1'b0;
        end else begin
            if (sof) begin
                stat_q <= 1'b1;
            end else if (stat_clr) begin
                stat_q <= 1'b0;
            end
            if (mask_set) begin
                mask_q <= 1'b1;
            end else if (mask_clr) begin
                mask_q <= 1'b0;
            end
        end
    end

    always_comb begin
        irq = stat_q & mask_q;
    end

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import lcdt_pkg::*;
#(
    parameter int CW = FLD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_ce,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic [CW-1:0]     pix_x,
    output logic [CW-1:0]     pix_y,
    output logic [FMT_W-1:0]  out_mode,
    output logic              irq
);

    timing_t       sh_cfg;
    phase_e        h_ph;
    phase_e        v_ph;
    logic [CW-1:0] h_cnt;
    logic [CW-1:0] v_cnt;
    logic          line_end;
    logic          frame_end;
    logic          stat_q;
    logic          mask_q;
    logic          stat_clr;
    logic          mask_set;
    logic          mask_clr;
    logic [CW-1:0] vbp_m1;
    logic          vbp_zero;

    always_comb begin
        vbp_zero = (sh_cfg.vbp == '0);
        vbp_m1   = sh_cfg.vbp[CW-1:0] - 1'b1;
        stat_clr = rd_en && (rd_addr == A_STAT);
        mask_set = wr_en && (wr_addr == A_IEN) && wr_data[0];
        mask_clr = wr_en && (wr_addr == A_IDIS) && wr_data[0];
    end

    lcdt_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .frame_end (frame_end),
        .stat_q    (stat_q),
        .mask_q    (mask_q),
        .sh_cfg    (sh_cfg),
        .rd_data   (rd_data)
    );

    lcdt_phase_fsm #(.CW(CW)) u_hfsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (pix_ce),
        .lim_sync  (sh_cfg.hsw_m1[CW-1:0]),
        .lim_back  (sh_cfg.hbp_m1[CW-1:0]),
        .lim_act   (sh_cfg.wid_m1[CW-1:0]),
        .lim_front (sh_cfg.hfp_m1[CW-1:0]),
        .skip_back (1'b0),
        .phase     (h_ph),
        .cnt       (h_cnt),
        .wrap      (line_end)
    );

    lcdt_phase_fsm #(.CW(CW)) u_vfsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (line_end),
        .lim_sync  (sh_cfg.vsw_m1[CW-1:0]),
        .lim_back  (vbp_m1),
        .lim_act   (sh_cfg.hgt_m1[CW-1:0]),
        .lim_front (sh_cfg.vfp_m1[CW-1:0]),
        .skip_back (vbp_zero),
        .phase     (v_ph),
        .cnt       (v_cnt),
        .wrap      (frame_end)
    );

    lcdt_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sof      (frame_end),
        .stat_clr (stat_clr),
        .mask_set (mask_set),
        .mask_clr (mask_clr),
        .stat_q   (stat_q),
        .mask_q   (mask_q),
        .irq      (irq)
    );

    // panel outputs
    always_comb begin
        hsync    = (h_ph == PH_SYNC) ^ sh_cfg.hs_inv;
        vsync    = (v_ph == PH_SYNC) ^ sh_cfg.vs_inv;
        de       = (h_ph == PH_ACTIVE) && (v_ph == PH_ACTIVE);
        pix_x    = (h_ph == PH_ACTIVE) ? h_cnt : '0;
        pix_y    = (v_ph == PH_ACTIVE) ? v_cnt : '0;
        out_mode = sh_cfg.fmt;
    end

endmodule

// File: rtl/lcdt_chk.sv
module lcdt_chk
    import lcdt_pkg::*;
#(
    parameter int CW = FLD_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pix_ce,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [REG_W-1:0]  wr_data,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              hsync,
    input logic              vsync,
    input logic              de,
    input logic [CW-1:0]     pix_x,
    input logic [CW-1:0]     pix_y,
    input logic [FMT_W-1:0]  out_mode,
    input logic              irq,
    input logic              stat_q,
    input logic              frame_end,
    input timing_t           sh_cfg
);

    // R4: data-enable never overlaps horizontal sync
    a_r4_de_outside_hsync: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (hsync == sh_cfg.hs_inv));

    // R4: data-enable never overlaps vertical sync
    a_r4_de_outside_vsync: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (vsync == sh_cfg.vs_inv));

    // R4: column stays inside the active width
    a_r4_x_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (pix_x <= sh_cfg.wid_m1[CW-1:0]));

    // R8: outputs hold without a pixel enable
    a_r8_hold_without_ce: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_ce |=> $stable({hsync, vsync, de, pix_x, pix_y, out_mode}));

    // R7: shadow configuration changes only at a frame boundary
    a_r7_shadow_frame_only: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(sh_cfg));

    // R9: start of frame sets status
    a_r9_sof_sets: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> stat_q);

    // R9: status is sticky until read
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q && !(rd_en && rd_addr == A_STAT)) |=> stat_q);

    // R9: read clears status when no event coincides
    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == A_STAT && !frame_end) |=> !stat_q);

    // R10: a disable write drops the interrupt
    a_r10_disable_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_IDIS && wr_data[0]) |=> !irq);

endmodule

bind lcd_timing_gen lcdt_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_ce    (pix_ce),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .hsync     (hsync),
    .vsync     (vsync),
    .de        (de),
    .pix_x     (pix_x),
    .pix_y     (pix_y),
    .out_mode  (out_mode),
    .irq       (irq),
    .stat_q    (stat_q),
    .frame_end (frame_end),
    .sh_cfg    (sh_cfg)
);

// File: tb/sim_lcd_timing_gen.sv
module sim_lcd_timing_gen;

    typedef struct {
        int hs;
        int vs;
        int de;
        int x;
        int y;
        int md;
    } pix_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_ce = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        hsync;
    logic        vsync;
    logic        de;
    logic [15:0] pix_x;
    logic [15:0] pix_y;
    logic [1:0]  out_mode;
    logic        irq;

    int   n_chk = 0;
    int   n_fail = 0;
    int   n_pop = 0;
    int   ce_ctr = 0;
    bit   ce_en = 1'b0;
    bit   mon_on = 1'b0;
    bit   done = 1'b0;
    pix_t exp_q[$];

    always #10 clk = ~clk;

    lcd_timing_gen u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_ce   (pix_ce),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .hsync    (hsync),
        .vsync    (vsync),
        .de       (de),
        .pix_x    (pix_x),
        .pix_y    (pix_y),
        .out_mode (out_mode),
        .irq      (irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    // pixel enable: low on every third cycle while running
    always @(posedge clk) begin
        #1;
        if (ce_en) begin
            ce_ctr++;
            pix_ce = (ce_ctr % 3) != 0;
        end else begin
            pix_ce = 1'b0;
        end
    end

    // driver: expected pixel stream of one frame
    task automatic push_frame(input int hsw, input int hbp, input int w, input int hfp,
                              input int vsw, input int vbp, input int h, input int vfp,
                              input int hi, input int vi, input int md);
        for (int ly = 0; ly < vsw + vbp + h + vfp; ly++) begin
            for (int px = 0; px < hsw + hbp + w + hfp; px++) begin
                pix_t it;
                int   hact;
                int   vact;
                hact  = (px >= hsw + hbp && px < hsw + hbp + w) ? 1 : 0;
                vact  = (ly >= vsw + vbp && ly < vsw + vbp + h) ? 1 : 0;
                it.hs = ((px < hsw) ? 1 : 0) ^ hi;
                it.vs = ((ly < vsw) ? 1 : 0) ^ vi;
                it.de = hact & vact;
                it.x  = hact ? px - hsw - hbp : 0;
                it.y  = vact ? ly - vsw - vbp : 0;
                it.md = md;
                exp_q.push_back(it);
            end
        end
    endtask

    // monitor: compare each enabled pixel
    always @(negedge clk) begin
        if (mon_on && pix_ce && exp_q.size() > 0) begin
            pix_t e;
            e = exp_q.pop_front();
            n_pop++;
            chk("R2/R5 hsync", int'(hsync), e.hs);
            chk("R3/R5 vsync", int'(vsync), e.vs);
            chk("R4 de", int'(de), e.de);
            chk("R4 pix_x", int'(pix_x), e.x);
            chk("R4 pix_y", int'(pix_y), e.y);
            chk("R6 out_mode", int'(out_mode), e.md);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk);
        #2;
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        #2;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(posedge clk);
        #2;
        rd_en = 1'b1;
        rd_addr = a;
        @(negedge clk);
        d = rd_data;
        @(posedge clk);
        #2;
        rd_en = 1'b0;
    endtask

    task automatic write_cfg(input int hsw, input int hbp, input int w, input int hfp,
                             input int vsw, input int vbp, input int h, input int vfp,
                             input int hi, input int vi, input int md);
        wr(3'd0, {16'(vsw - 1), 16'(hsw - 1)});
        wr(3'd1, {16'(vbp), 16'(vfp - 1)});
        wr(3'd2, {16'(hbp - 1), 16'(hfp - 1)});
        wr(3'd3, {16'(h - 1), 16'(w - 1)});
        wr(3'd4, {22'd0, 2'(md), 6'd0, 1'(vi), 1'(hi)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int          seen;
        repeat (4) @(posedge clk);
        #2;
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 hsync", int'(hsync), 1);
        chk("R1 vsync", int'(vsync), 1);
        chk("R1 de", int'(de), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 out_mode", int'(out_mode), 0);
        rd(3'd7, d);
        chk("R1 status", int'(d), 0);

        // R7: frame A (reset defaults) runs out before config B applies
        push_frame(1, 1, 1, 1, 1, 0, 1, 1, 0, 0, 0);
        push_frame(2, 2, 4, 1, 1, 2, 3, 1, 0, 0, 3);
        push_frame(2, 2, 4, 1, 1, 2, 3, 1, 0, 0, 3);
        // R3/R5/R6: config C, zero back porch, inverted syncs
        push_frame(1, 1, 3, 2, 2, 0, 2, 2, 1, 1, 2);
        push_frame(1, 1, 3, 2, 2, 0, 2, 2, 1, 1, 2);
        write_cfg(2, 2, 4, 1, 1, 2, 3, 1, 0, 0, 3);
        mon_on = 1'b1;
        ce_en = 1'b1;

        // R7: write C in the middle of the second B frame
        while (n_pop < 12 + 63 + 5) @(negedge clk);
        write_cfg(1, 1, 3, 2, 2, 0, 2, 2, 1, 1, 2);
        while (exp_q.size() > 0) @(negedge clk);
        chk("R2 stream drained", n_pop, 12 + 63 * 2 + 42 * 2);

        // R9/R10: interrupt behaviour with the pixel clock stalled
        @(posedge clk);
        #2;
        ce_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 irq masked", int'(irq), 0);
        rd(3'd7, d);
        chk("R9 status set by sof", int'(d[0]), 1);
        chk("R10 mask clear", int'(d[1]), 0);
        rd(3'd7, d);
        chk("R9 read clears status", int'(d[0]), 0);
        wr(3'd5, 32'd1);
        @(negedge clk);
        chk("R10 irq no status", int'(irq), 0);

        ce_en = 1'b1;
        seen = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (irq) begin
                seen = 1;
                break;
            end
        end
        chk("R10 irq raised", seen, 1);
        @(posedge clk);
        #2;
        ce_en = 1'b0;
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk("R9 irq sticky", int'(irq), 1);
        wr(3'd6, 32'd1);
        @(negedge clk);
        chk("R10 disable gates irq", int'(irq), 0);
        wr(3'd5, 32'd1);
        @(negedge clk);
        chk("R10 re-enable irq", int'(irq), 1);
        rd(3'd7, d);
        chk("R9 status held", int'(d[0]), 1);
        chk("R10 mask set", int'(d[1]), 1);
        @(negedge clk);
        chk("R9 irq after read", int'(irq), 0);
        finish_run();
    end

endmodule